// File: doc/BRIEF.md
# Slot Transaction Gather Selector

This block sits between a load/store slot table and a 128-bit memory port. Each cycle it looks at the table's pending byte entries (an active flag, a 32-bit byte address and a write byte per entry) and forms one bus beat from them. The lowest-numbered pending entry sets the beat. Every other pending entry whose address lies in the same 16-byte aligned window joins that beat, whether or not it sits next to the first one in the table. The block drives the aligned beat address, a per-lane byte enable, the write bytes steered to their lanes and a byte count.

When the memory port accepts the beat, the block records which entries the beat covered and which lane each used. In the following cycle, which is when read data comes back, it reports the served entries as a bitmask so the owner of the table can clear their active flags. For a load it also hands each served entry the byte taken from its own lane of the returned data. No new beat is offered in that reply cycle, so the table owner has time to clear the flags.

Top module: `slot_gather_sel`

## Requirements
- R1: After reset, `bus_valid` and `done_valid` are 0 and `done_served` is all zero.
- R2: The beat is formed around the active entry with the lowest index. `bus_addr` equals that entry's address with bits [3:0] cleared.
- R3: Every active entry whose address bits [31:4] match those of the lowest active entry is included, contiguous or not. Entries with other upper bits are left for a later beat.
- R4: `bus_wmask` bit k is 1 exactly when an included entry has address bits [3:0] equal to k. Byte lane k of `bus_wdata` (bits 8k+7..8k) carries that entry's write byte, and unused lanes are zero. `bus_write` is 1 for stores and 0 for loads (`slot_is_load` = 1).
- R5: `bus_size` is the number of included bytes as a 5-bit count, so 16 for a full beat.
- R6: If several active entries share a lane in the same window, only the lowest-indexed of them is included. The others stay pending for a later beat.
- R7: With no active entry, `txn_none` is 1 and `bus_valid` is 0.
- R8: While `bus_ready` is 0 and the table does not change, the offered beat (valid, address, mask, data, size) holds steady.
- R9: One cycle after `bus_valid && bus_ready`, `done_valid` is 1 for exactly one cycle, and `done_served` has bit i set for each entry the accepted beat included. `bus_valid` is 0 in that cycle.
- R10: In the `done_valid` cycle of a load, byte i of `done_rbytes` (bits 8i+7..8i) is the byte from lane (address[3:0] of entry i) of `bus_rdata` for each served entry, and zero for other entries. For a store, all of `done_rbytes` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_active | input | 16 | Per-entry pending flag |
| slot_addr | input | 512 | Entry i byte address in bits 32i+31..32i |
| slot_wbyte | input | 128 | Entry i write byte in bits 8i+7..8i |
| slot_is_load | input | 1 | 1: the slot holds a load; 0: a store |
| bus_valid | output | 1 | Beat offered |
| bus_ready | input | 1 | Beat accepted this cycle |
| bus_addr | output | 32 | 16-byte aligned beat address |
| bus_size | output | 5 | Number of bytes in the beat |
| bus_wmask | output | 16 | Byte lane enables |
| bus_wdata | output | 128 | Write bytes placed in their lanes |
| bus_write | output | 1 | 1 for a store beat |
| bus_rdata | input | 128 | Read data, valid the cycle after acceptance |
| txn_none | output | 1 | No entry is pending |
| done_valid | output | 1 | Reply cycle of an accepted beat |
| done_served | output | 16 | Entries covered by the accepted beat |
| done_rbytes | output | 128 | Per-entry load bytes taken from their lanes |

## Verification
The hardest case to reach from the ports is a lane collision: two pending entries with the same address in one window while other entries of that window are spread across the table. The collision has to push the later duplicate into a second beat without stopping the rest of the window from being bundled. The bench builds such a table directly. It serves it one beat at a time and clears the reported entries itself. It then checks that the duplicate comes back alone on the next beat. A byte-store sequence that straddles a window boundary, and a full sixteen-lane beat loaded in reverse table order, cover both ends of the byte count.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic {
      GATE_OPEN = 1'b0,
      GATE_WAIT = 1'b1
   } gate_state_e;

   // selects the structure of the lowest-index finder
   localparam int PICK_CHAIN  = 0;
   localparam int PICK_PREFIX = 1;
endpackage

// File: rtl/sgs_anchor_pick.sv
module sgs_anchor_pick #(
   parameter int N_ENT      = 16,
   parameter int PICK_STYLE = sgs_pkg::PICK_PREFIX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_ENT-1:0] act,
   output logic [N_ENT-1:0] anchor_oh,
   output logic             any_act
);
   localparam int LV = (N_ENT > 1) ? $clog2(N_ENT) : 1;

   logic [N_ENT-1:0] below;   // some lower entry is active

   if (N_ENT < 1) begin : g_bad_n
      $error("sgs_anchor_pick: N_ENT must be at least 1");
   end

   if (PICK_STYLE == sgs_pkg::PICK_CHAIN) begin : g_chain
      always_comb begin
         logic acc;
         acc = 1'b0;
         for (int i = 0; i < N_ENT; i++) begin
            below[i] = acc;
            acc      = acc | act[i];
         end
      end
   end else begin : g_prefix
      logic [LV:0][N_ENT-1:0] pre;
      assign pre[0] = act;
      for (genvar l = 0; l < LV; l++) begin : g_lvl
         for (genvar i = 0; i < N_ENT; i++) begin : g_bit
            if (i >= (1 << l)) begin : g_or
               assign pre[l+1][i] = pre[l][i] | pre[l][i-(1<<l)];
            end else begin : g_pass
               assign pre[l+1][i] = pre[l][i];
            end
         end
      end
      assign below[0] = 1'b0;
      for (genvar i = 1; i < N_ENT; i++) begin : g_below
         assign below[i] = pre[LV][i-1];
      end
   end

   assign anchor_oh = act & ~below;
   assign any_act   = |act;

   // R2: a single anchor, and no active entry ranks below it
   p_anchor_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |-> ($onehot0(anchor_oh) && (anchor_oh != '0) &&
                   (((anchor_oh - 1'b1) & act) == '0)));
endmodule

// File: rtl/sgs_beat_gather.sv
module sgs_beat_gather #(
   parameter int N_ENT      = 16,
   parameter int ADDR_W     = 32,
   parameter int BEAT_BYTES = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [N_ENT-1:0]                    act,
   input  logic [N_ENT*ADDR_W-1:0]             addr_flat,
   input  logic [N_ENT*sgs_pkg::BYTE_W-1:0]    wbyte_flat,
   input  logic [N_ENT-1:0]                    anchor_oh,
   output logic [N_ENT-1:0]                    sel,
   output logic [N_ENT*$clog2(BEAT_BYTES)-1:0] lane_flat,
   output logic [ADDR_W-1:0]                   beat_addr,
   output logic [BEAT_BYTES-1:0]               lane_mask,
   output logic [BEAT_BYTES*sgs_pkg::BYTE_W-1:0] lane_data,
   output logic [$clog2(BEAT_BYTES):0]         byte_cnt
);
   import sgs_pkg::*;
   localparam int LANE_W = $clog2(BEAT_BYTES);
   localparam int TAG_W  = ADDR_W - LANE_W;
   localparam int SIZE_W = LANE_W + 1;

   if ((1 << LANE_W) != BEAT_BYTES || BEAT_BYTES < 2) begin : g_bad_beat
      $error("sgs_beat_gather: BEAT_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= LANE_W) begin : g_bad_addr
      $error("sgs_beat_gather: ADDR_W too narrow for the beat");
   end

   logic [TAG_W-1:0]  tag  [N_ENT];
   logic [LANE_W-1:0] lane [N_ENT];
   logic [BYTE_W-1:0] wb   [N_ENT];
   logic [TAG_W-1:0]  anchor_tag;
   logic [N_ENT-1:0]  in_win;

   for (genvar i = 0; i < N_ENT; i++) begin : g_split
      assign tag[i]  = addr_flat[i*ADDR_W+LANE_W +: TAG_W];
      assign lane[i] = addr_flat[i*ADDR_W +: LANE_W];
      assign wb[i]   = wbyte_flat[i*BYTE_W +: BYTE_W];
      assign lane_flat[i*LANE_W +: LANE_W] = lane[i];
      assign in_win[i] = act[i] && (tag[i] == anchor_tag);
   end

   always_comb begin
      anchor_tag = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (anchor_oh[i]) anchor_tag = anchor_tag | tag[i];
      end
   end

   // a later entry yields its lane to an earlier one in the same window
   always_comb begin
      for (int i = 0; i < N_ENT; i++) begin
         logic taken;
         taken = 1'b0;
         for (int j = 0; j < i; j++) begin
            if (in_win[j] && (lane[j] == lane[i])) taken = 1'b1;
         end
         sel[i] = in_win[i] && !taken;
      end
   end

   always_comb begin
      lane_mask = '0;
      lane_data = '0;
      byte_cnt  = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (sel[i]) begin
            lane_mask[lane[i]]                 = 1'b1;
            lane_data[lane[i]*BYTE_W +: BYTE_W] = wb[i];
            byte_cnt                            = byte_cnt + SIZE_W'(1);
         end
      end
   end

   assign beat_addr = {anchor_tag, {LANE_W{1'b0}}};

   // R5: count and enables agree
   p_size_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(byte_cnt) == $countones(lane_mask)));
   // R6: no two included entries share a lane
   p_lane_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(sel) == $countones(lane_mask)));
   // R3: the anchor always rides in its own beat
   p_anchor_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (anchor_oh != '0) |-> ((sel & anchor_oh) == anchor_oh));
endmodule

// File: rtl/sgs_lane_scatter.sv
module sgs_lane_scatter #(
   parameter int N_ENT      = 16,
   parameter int BEAT_BYTES = 16
) (
   input  logic [N_ENT-1:0]                      served,
   input  logic                                  is_load,
   input  logic [N_ENT*$clog2(BEAT_BYTES)-1:0]   lane_flat,
   input  logic [BEAT_BYTES*sgs_pkg::BYTE_W-1:0] rdata,
   output logic [N_ENT*sgs_pkg::BYTE_W-1:0]      ent_bytes
);
   import sgs_pkg::*;
   localparam int LANE_W = $clog2(BEAT_BYTES);

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      logic [LANE_W-1:0] ln;
      assign ln = lane_flat[i*LANE_W +: LANE_W];
      assign ent_bytes[i*BYTE_W +: BYTE_W] =
         (served[i] && is_load) ? rdata[ln*BYTE_W +: BYTE_W] : '0;
   end
endmodule

// File: rtl/slot_gather_sel.sv
module slot_gather_sel #(
   parameter int N_ENT      = 16,
   parameter int ADDR_W     = 32,
   parameter int BEAT_BYTES = 16,
   parameter int PICK_STYLE = sgs_pkg::PICK_PREFIX
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_ENT-1:0]              slot_active,
   input  logic [N_ENT*ADDR_W-1:0]       slot_addr,
   input  logic [N_ENT*8-1:0]            slot_wbyte,
   input  logic                          slot_is_load,
   output logic                          bus_valid,
   input  logic                          bus_ready,
   output logic [ADDR_W-1:0]             bus_addr,
   output logic [$clog2(BEAT_BYTES):0]   bus_size,
   output logic [BEAT_BYTES-1:0]         bus_wmask,
   output logic [BEAT_BYTES*8-1:0]       bus_wdata,
   output logic                          bus_write,
   input  logic [BEAT_BYTES*8-1:0]       bus_rdata,
   output logic                          txn_none,
   output logic                          done_valid,
   output logic [N_ENT-1:0]              done_served,
   output logic [N_ENT*8-1:0]            done_rbytes
);
   import sgs_pkg::*;
   localparam int LANE_W = $clog2(BEAT_BYTES);

   if (PICK_STYLE != PICK_CHAIN && PICK_STYLE != PICK_PREFIX) begin : g_bad_style
      $error("slot_gather_sel: unknown PICK_STYLE");
   end

   logic [N_ENT-1:0]        anchor_oh;
   logic                    any_act;
   logic [N_ENT-1:0]        sel;
   logic [N_ENT*LANE_W-1:0] lane_flat;
   gate_state_e             st_q;
   logic [N_ENT-1:0]        pend_served_q;
   logic [N_ENT*LANE_W-1:0] pend_lane_q;
   logic                    pend_load_q;
   logic                    hs;

   sgs_anchor_pick #(.N_ENT(N_ENT), .PICK_STYLE(PICK_STYLE)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (slot_active),
      .anchor_oh (anchor_oh),
      .any_act   (any_act)
   );

   sgs_beat_gather #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_gather (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (slot_active),
      .addr_flat  (slot_addr),
      .wbyte_flat (slot_wbyte),
      .anchor_oh  (anchor_oh),
      .sel        (sel),
      .lane_flat  (lane_flat),
      .beat_addr  (bus_addr),
      .lane_mask  (bus_wmask),
      .lane_data  (bus_wdata),
      .byte_cnt   (bus_size)
   );

   assign bus_valid = any_act && (st_q == GATE_OPEN);
   assign bus_write = !slot_is_load;
   assign txn_none  = !any_act;
   assign hs        = bus_valid && bus_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= GATE_OPEN;
         pend_served_q <= '0;
         pend_lane_q   <= '0;
         pend_load_q   <= 1'b0;
      end else if (st_q == GATE_WAIT) begin
         st_q          <= GATE_OPEN;
         pend_served_q <= '0;
      end else if (hs) begin
         st_q          <= GATE_WAIT;
         pend_served_q <= sel;
         pend_lane_q   <= lane_flat;
         pend_load_q   <= slot_is_load;
      end
   end

   assign done_valid  = (st_q == GATE_WAIT);
   assign done_served = pend_served_q;

   sgs_lane_scatter #(.N_ENT(N_ENT), .BEAT_BYTES(BEAT_BYTES)) u_scatter (
      .served    (pend_served_q),
      .is_load   (pend_load_q),
      .lane_flat (pend_lane_q),
      .rdata     (bus_rdata),
      .ent_bytes (done_rbytes)
   );

   // R7: nothing offered without a pending entry
   p_req_needs_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (slot_active != '0));
   p_none_blocks_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      txn_none |-> !bus_valid);
   // R9: reply one cycle after acceptance, single pulse, port quiet meanwhile
   p_done_after_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_ready) |=> done_valid);
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);
   p_quiet_in_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> !bus_valid);
   // R3: every served entry was pending when the beat went out
   p_served_was_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> ((done_served & ~$past(slot_active)) == '0));
   // R10: a store reply never carries bytes
   p_store_no_bytes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !$past(slot_is_load)) |-> (done_rbytes == '0));
endmodule

// File: tb/slot_gather_sel_tb.sv
module slot_gather_sel_tb;
   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  act_b;
   logic [31:0]   addr_b [N];
   logic [7:0]    wb_b   [N];
   logic          is_load = 1'b0;
   logic          bus_ready = 1'b0;
   logic [127:0]  bus_rdata = '0;

   logic [N*32-1:0] slot_addr;
   logic [N*8-1:0]  slot_wbyte;
   logic            bus_valid, bus_write, txn_none, done_valid;
   logic [31:0]     bus_addr;
   logic [4:0]      bus_size;
   logic [15:0]     bus_wmask;
   logic [127:0]    bus_wdata;
   logic [N-1:0]    done_served;
   logic [N*8-1:0]  done_rbytes;

   int vectors = 0;
   int miscompares = 0;

   always #2.5 clk = ~clk;

   for (genvar i = 0; i < N; i++) begin : g_pack
      assign slot_addr[i*32 +: 32] = addr_b[i];
      assign slot_wbyte[i*8 +: 8]  = wb_b[i];
   end

   slot_gather_sel u_dut (
      .clk (clk), .rst_n (rst_n),
      .slot_active (act_b), .slot_addr (slot_addr), .slot_wbyte (slot_wbyte),
      .slot_is_load (is_load),
      .bus_valid (bus_valid), .bus_ready (bus_ready), .bus_addr (bus_addr),
      .bus_size (bus_size), .bus_wmask (bus_wmask), .bus_wdata (bus_wdata),
      .bus_write (bus_write), .bus_rdata (bus_rdata), .txn_none (txn_none),
      .done_valid (done_valid), .done_served (done_served),
      .done_rbytes (done_rbytes)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_table();
      act_b = '0;
      for (int i = 0; i < N; i++) begin
         addr_b[i] = '0;
         wb_b[i]   = '0;
      end
   endtask

   // Offer, accept and reply one beat; expected values given by the caller.
   task automatic serve_beat(input string tag, input logic [31:0] e_addr,
                             input logic [15:0] e_mask, input logic [N-1:0] e_srv);
      logic [127:0] e_wd;
      logic [127:0] e_rb;
      logic [127:0] rd;
      e_wd = '0;
      e_rb = '0;
      for (int i = 0; i < N; i++)
         if (e_srv[i]) e_wd[addr_b[i][3:0]*8 +: 8] = wb_b[i];
      #1;
      chk(bus_valid === 1'b1, {tag, " R2 valid"}, 128'(bus_valid), 128'd1);
      chk(bus_addr === e_addr, {tag, " R2 addr"}, 128'(bus_addr), 128'(e_addr));
      chk(bus_wmask === e_mask, {tag, " R3 R4 mask"}, 128'(bus_wmask), 128'(e_mask));
      chk(bus_size === 5'($countones(e_mask)), {tag, " R5 size"},
          128'(bus_size), 128'($countones(e_mask)));
      chk(bus_wdata === e_wd, {tag, " R4 wdata"}, bus_wdata, e_wd);
      chk(bus_write === !is_load, {tag, " R4 dir"}, 128'(bus_write), 128'(!is_load));
      bus_ready = 1'b1;
      @(negedge clk);
      bus_ready = 1'b0;
      for (int k = 0; k < 16; k++) rd[k*8 +: 8] = 8'h40 + 8'(k);
      bus_rdata = rd;
      if (is_load)
         for (int i = 0; i < N; i++)
            if (e_srv[i]) e_rb[i*8 +: 8] = rd[addr_b[i][3:0]*8 +: 8];
      #1;
      chk(done_valid === 1'b1, {tag, " R9 done"}, 128'(done_valid), 128'd1);
      chk(done_served === e_srv, {tag, " R9 served"}, 128'(done_served), 128'(e_srv));
      chk(bus_valid === 1'b0, {tag, " R9 quiet"}, 128'(bus_valid), 128'd0);
      chk(done_rbytes === e_rb, {tag, " R10 bytes"}, done_rbytes, e_rb);
      act_b = act_b & ~done_served;
      @(negedge clk);
      #1;
      chk(done_valid === 1'b0, {tag, " R9 pulse"}, 128'(done_valid), 128'd0);
      bus_rdata = '0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      #1;
      chk(bus_valid === 1'b0, "R1 valid", 128'(bus_valid), 128'd0);
      chk(done_valid === 1'b0, "R1 done", 128'(done_valid), 128'd0);
      chk(done_served === '0, "R1 served", 128'(done_served), 128'd0);
   endtask

   task automatic t_straddle_store();
      clear_table();
      is_load = 1'b0;
      for (int i = 0; i < 4; i++) begin
         addr_b[i] = 32'h1000_00EF + 32'(i);
         wb_b[i]   = 8'h11 * 8'(i + 1);
      end
      act_b = 16'h000F;
      serve_beat("straddle1", 32'h1000_00E0, 16'h8000, 16'h0001);
      serve_beat("straddle2", 32'h1000_00F0, 16'h0007, 16'h000E);
   endtask

   task automatic t_sparse_store();
      clear_table();
      is_load = 1'b0;
      addr_b[1] = 32'h0000_2003; wb_b[1] = 8'hA1;
      addr_b[2] = 32'h0000_3005; wb_b[2] = 8'hB2;
      addr_b[3] = 32'h0000_200A; wb_b[3] = 8'hC3;
      addr_b[5] = 32'h0000_200F; wb_b[5] = 8'hD5;
      addr_b[0] = 32'h0000_2001; wb_b[0] = 8'hEE;   // inactive: R3 must skip it
      act_b = 16'h002E;
      serve_beat("sparse1 R3", 32'h0000_2000, 16'h8408, 16'h002A);
      serve_beat("sparse2 R3", 32'h0000_3000, 16'h0020, 16'h0004);
   endtask

   task automatic t_dup_lane();
      clear_table();
      is_load = 1'b0;
      addr_b[0] = 32'h0000_4004; wb_b[0] = 8'hAA;
      addr_b[1] = 32'h0000_4004; wb_b[1] = 8'hBB;
      addr_b[2] = 32'h0000_4006; wb_b[2] = 8'hCC;
      act_b = 16'h0007;
      serve_beat("dup1 R6", 32'h0000_4000, 16'h0050, 16'h0005);
      serve_beat("dup2 R6", 32'h0000_4000, 16'h0010, 16'h0002);
   endtask

   task automatic t_load_scatter();
      clear_table();
      is_load = 1'b1;
      addr_b[0] = 32'h0000_5001;
      addr_b[1] = 32'h0000_5003;
      addr_b[2] = 32'h0000_5002;
      addr_b[3] = 32'h0000_6000;
      act_b = 16'h000F;
      serve_beat("load1 R10", 32'h0000_5000, 16'h000E, 16'h0007);
      serve_beat("load2 R10", 32'h0000_6000, 16'h0001, 16'h0008);
      is_load = 1'b0;
   endtask

   task automatic t_full_beat();
      clear_table();
      is_load = 1'b0;
      for (int i = 0; i < N; i++) begin
         addr_b[i] = 32'h0000_7000 + 32'(15 - i);
         wb_b[i]   = 8'(i) ^ 8'h5A;
      end
      act_b = 16'hFFFF;
      serve_beat("full R5", 32'h0000_7000, 16'hFFFF, 16'hFFFF);
   endtask

   task automatic t_none();
      clear_table();
      #1;
      chk(txn_none === 1'b1, "R7 none", 128'(txn_none), 128'd1);
      chk(bus_valid === 1'b0, "R7 valid", 128'(bus_valid), 128'd0);
      @(negedge clk);
   endtask

   task automatic t_stall();
      logic [31:0]  a0;
      logic [15:0]  m0;
      logic [127:0] d0;
      clear_table();
      is_load = 1'b0;
      addr_b[4] = 32'h0000_8009; wb_b[4] = 8'h99;
      addr_b[9] = 32'h0000_800C; wb_b[9] = 8'h77;
      act_b = 16'h0210;
      #1;
      a0 = bus_addr; m0 = bus_wmask; d0 = bus_wdata;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         #1;
         chk(bus_valid === 1'b1 && bus_addr === a0 && bus_wmask === m0 &&
             bus_wdata === d0 && bus_size === 5'd2, "R8 hold",
             {bus_addr, bus_wmask, bus_size}, {a0, m0, 5'd2});
      end
      @(negedge clk);
      serve_beat("stall R8", 32'h0000_8000, 16'h1200, 16'h0210);
   endtask

   initial begin
      clear_table();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_none();
      t_straddle_store();
      t_sparse_store();
      t_dup_lane();
      t_load_scatter();
      t_full_beat();
      t_stall();
      t_none();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule